// File: doc/BRIEF.md
# Pseudo-SRAM Access Controller

This block sits between a synchronous request port and an asynchronous 16-bit pseudo-SRAM. A requester presents an address, a write flag, two byte enables and write data. The controller turns each accepted request into one chip-select-framed memory cycle and, for reads, returns the selected bytes with a single-cycle valid strobe. All memory-side strobes come from registered state, so no combinational path runs from the request port to the pins.

After reset, and again after waking from the data-losing standby, the controller runs the start-up sequence on its own. It first holds chip select and the mode pin high for a parameterised wait. It then performs three chip-select-framed reads with output enable kept high. Until that sequence is done, it does not offer ready. A sleep request taken while idle parks the memory in the data-retaining standby or, when the deep flag is set, in the data-losing standby. Each timing figure is given as a clock count parameter. Chip select is always released at the end of every access, so no single cycle can approach the memory's upper cycle-time limit.

Top module: `psram_ctrl`

## Requirements
- R1: From reset release, chip select and mode stay high and ready stays low for at least INIT_WAIT_CYC clocks before the first memory cycle.
- R2: During reset ready is low, chip select is high, mode is high and the data bus is not driven. After the wait, exactly three chip-select pulses occur with output enable high, and only then does ready go high.
- R3: Chip select stays low for at least CYC_MIN_CYC clocks in every memory cycle.
- R4: Between two chip-select low phases, chip select is high for at least CS_GAP_CYC clocks.
- R5: The memory address never changes while chip select and write enable are both low.
- R6: Write enable is low for at least WE_PULSE_CYC clocks per write, and the data bus is driven only while write enable is low.
- R7: Output enable is never low together with write enable. The data bus is released at least one clock before output enable goes low.
- R8: A read returns the memory word, with lanes whose enable is 0 forced to zero. Bit 0 of the byte enable selects data bits 7:0 (lower byte select) and bit 1 selects bits 15:8 (upper byte select). The valid strobe lasts exactly one cycle.
- R9: A write changes only the byte lanes whose enable bit is 1.
- R10: A sleep request with the deep flag 0 keeps chip select and mode high and drops ready. Releasing it restores ready with no chip-select pulse in between.
- R11: With the deep flag 1, mode goes low only while chip select is high. Releasing the request reruns the full start-up wait and the three reads before ready returns.
- R12: Mode is high at all times except while parked in the data-losing standby.
- R13: Chip select never stays low for more than MAX_CS_LOW_CYC consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present; taken when ready_o is high |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_be_i | input | 2 | Byte enables (bit 0 = bits 7:0) |
| req_wdata_i | input | 16 | Write data |
| sleep_req_i | input | 1 | Hold high to stay in standby |
| sleep_deep_i | input | 1 | Standby kind sampled on entry: 1 = data-losing |
| ready_o | output | 1 | Idle and able to take a request |
| rdata_valid_o | output | 1 | One-cycle read data strobe |
| rdata_o | output | 16 | Masked read data |
| ram_addr_o | output | ADDR_W | Memory address |
| ram_cs_no | output | 1 | Chip select, active low |
| ram_we_no | output | 1 | Write enable, active low |
| ram_oe_no | output | 1 | Output enable, active low |
| ram_lb_no | output | 1 | Lower byte select, active low |
| ram_ub_no | output | 1 | Upper byte select, active low |
| ram_mode_o | output | 1 | Standby mode pin |
| ram_dq_o | output | 16 | Data toward memory |
| ram_dq_oe_o | output | 1 | Data bus drive enable |
| ram_dq_i | input | 16 | Data from memory |

## Verification
The assertions assume that a request is presented only while ready is high, and that it is held for exactly the cycle in which it is taken. They also assume the sleep request is raised only while no request is pending, and that the deep flag is steady during the whole sleep. The stimulus drives every request and sleep edge a short delay after a rising clock edge, and only once ready has been seen high. Requests and sleep never overlap. The memory model answers reads with the full stored word, so lane masking must come from the controller itself.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [3:0] {
    ST_INIT_WAIT,
    ST_INIT_RD,
    ST_INIT_GAP,
    ST_IDLE,
    ST_RD,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_REC,
    ST_GAP,
    ST_SLEEP
  } psram_st_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/psram_seq.sv
module psram_seq
  import psram_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int BE_W     = 2,
  parameter int CNT_W    = 16,
  parameter int INIT_CYC = 25000,
  parameter int RD_CYC   = 10,
  parameter int GAP_CYC  = 2,
  parameter int WP_CYC   = 4,
  parameter int REC_CYC  = 5,
  parameter int N_DUMMY  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              sleep_req_i,
  input  logic              sleep_deep_i,
  output psram_st_e         state_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BE_W-1:0]   be_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              deep_o,
  output logic              capture_o,
  output logic              ready_o
);
  localparam int DUM_W = $clog2(N_DUMMY + 1);

  psram_st_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DUM_W-1:0]  dum_q, dum_d;
  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] wdata_q;
  logic              deep_q;
  logic              done, accept, go_sleep;

  assign done     = (cnt_q == '0);
  assign accept   = (st_q == ST_IDLE) && req_valid_i;
  assign go_sleep = (st_q == ST_IDLE) && !req_valid_i && sleep_req_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = done ? cnt_q : cnt_q - 1'b1;
    dum_d = dum_q;
    unique case (st_q)
      ST_INIT_WAIT: if (done) begin
        st_d  = ST_INIT_RD;
        cnt_d = CNT_W'(RD_CYC - 1);
      end
      ST_INIT_RD: if (done) begin
        st_d  = ST_INIT_GAP;
        cnt_d = CNT_W'(GAP_CYC - 1);
        dum_d = dum_q + 1'b1;
      end
      ST_INIT_GAP: if (done) begin
        if (dum_q == DUM_W'(N_DUMMY)) begin
          st_d = ST_IDLE;
        end else begin
          st_d  = ST_INIT_RD;
          cnt_d = CNT_W'(RD_CYC - 1);
        end
      end
      ST_IDLE: begin
        if (accept) begin
          st_d  = req_write_i ? ST_WR_SETUP : ST_RD;
          cnt_d = req_write_i ? '0 : CNT_W'(RD_CYC - 1);
        end else if (go_sleep) begin
          st_d = ST_SLEEP;
        end
      end
      ST_RD: if (done) begin
        st_d  = ST_GAP;
        cnt_d = CNT_W'(GAP_CYC - 1);
      end
      ST_WR_SETUP: begin
        st_d  = ST_WR_PULSE;
        cnt_d = CNT_W'(WP_CYC - 1);
      end
      ST_WR_PULSE: if (done) begin
        st_d  = ST_WR_REC;
        cnt_d = CNT_W'(REC_CYC - 1);
      end
      ST_WR_REC: if (done) begin
        st_d  = ST_GAP;
        cnt_d = CNT_W'(GAP_CYC - 1);
      end
      ST_GAP: if (done) st_d = ST_IDLE;
      ST_SLEEP: if (!sleep_req_i) begin
        if (deep_q) begin
          st_d  = ST_INIT_WAIT;
          cnt_d = CNT_W'(INIT_CYC - 1);
          dum_d = '0;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_INIT_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_INIT_WAIT;
      cnt_q   <= CNT_W'(INIT_CYC - 1);
      dum_q   <= '0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      deep_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      dum_q <= dum_d;
      if (accept) begin
        addr_q  <= req_addr_i;
        be_q    <= req_be_i;
        wdata_q <= req_wdata_i;
      end
      if (go_sleep) deep_q <= sleep_deep_i;
    end
  end

  assign state_o   = st_q;
  assign addr_o    = addr_q;
  assign be_o      = be_q;
  assign wdata_o   = wdata_q;
  assign deep_o    = deep_q;
  assign capture_o = (st_q == ST_RD) && done;
  assign ready_o   = (st_q == ST_IDLE);
endmodule

// File: rtl/psram_pins.sv
module psram_pins
  import psram_pkg::*;
#(
  parameter int BE_W = 2
) (
  input  psram_st_e       state_i,
  input  logic [BE_W-1:0] be_i,
  input  logic            deep_i,
  output logic            cs_no,
  output logic            we_no,
  output logic            oe_no,
  output logic [BE_W-1:0] bsel_no,
  output logic            mode_o,
  output logic            dq_oe_o
);
  logic access_st;

  assign access_st = (state_i == ST_RD) || (state_i == ST_WR_SETUP) ||
                     (state_i == ST_WR_PULSE) || (state_i == ST_WR_REC);

  assign cs_no   = !(access_st || (state_i == ST_INIT_RD));
  assign we_no   = (state_i != ST_WR_PULSE);
  assign oe_no   = (state_i != ST_RD);
  assign dq_oe_o = (state_i == ST_WR_PULSE);
  assign mode_o  = !((state_i == ST_SLEEP) && deep_i);

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign bsel_no[g] = !((state_i == ST_INIT_RD) || (access_st && be_i[g]));
  end
endmodule

// File: rtl/psram_rdpath.sv
module psram_rdpath #(
  parameter int BE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [BE_W*8-1:0] dq_i,
  output logic [BE_W*8-1:0] rdata_o,
  output logic              valid_o
);
  logic [BE_W*8-1:0] rdata_q;
  logic              valid_q;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        rdata_q[g*8 +: 8] <= '0;
      else if (capture_i) rdata_q[g*8 +: 8] <= be_i[g] ? dq_i[g*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= capture_i;
  end

  assign rdata_o = rdata_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int ADDR_W         = 20,
  parameter int INIT_WAIT_CYC  = 25000,
  parameter int CYC_MIN_CYC    = 10,
  parameter int RD_LAT_CYC     = 10,
  parameter int CS_GAP_CYC     = 2,
  parameter int WE_PULSE_CYC   = 4,
  parameter int WR_REC_CYC     = 3,
  parameter int MAX_CS_LOW_CYC = 1250
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_be_i,
  input  logic [15:0]       req_wdata_i,
  input  logic              sleep_req_i,
  input  logic              sleep_deep_i,
  output logic              ready_o,
  output logic              rdata_valid_o,
  output logic [15:0]       rdata_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_cs_no,
  output logic              ram_we_no,
  output logic              ram_oe_no,
  output logic              ram_lb_no,
  output logic              ram_ub_no,
  output logic              ram_mode_o,
  output logic [15:0]       ram_dq_o,
  output logic              ram_dq_oe_o,
  input  logic [15:0]       ram_dq_i
);
  localparam int BE_W    = 2;
  localparam int DATA_W  = BE_W * 8;
  localparam int RD_LOW  = imin(imax(RD_LAT_CYC, CYC_MIN_CYC), MAX_CS_LOW_CYC);
  localparam int WR_TAIL = imax(WR_REC_CYC, CYC_MIN_CYC - 1 - WE_PULSE_CYC);
  localparam int CNT_W   = $clog2(imax(INIT_WAIT_CYC, MAX_CS_LOW_CYC) + 1);

  psram_st_e         state;
  logic [BE_W-1:0]   be_q;
  logic [BE_W-1:0]   bsel_n;
  logic              deep_q, capture;

  psram_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .CNT_W(CNT_W),
    .INIT_CYC(INIT_WAIT_CYC), .RD_CYC(RD_LOW), .GAP_CYC(CS_GAP_CYC),
    .WP_CYC(WE_PULSE_CYC), .REC_CYC(WR_TAIL), .N_DUMMY(3)
  ) u_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_addr_i, .req_be_i,
    .req_wdata_i, .sleep_req_i, .sleep_deep_i,
    .state_o(state), .addr_o(ram_addr_o), .be_o(be_q), .wdata_o(ram_dq_o),
    .deep_o(deep_q), .capture_o(capture), .ready_o(ready_o)
  );

  psram_pins #(.BE_W(BE_W)) u_pins (
    .state_i(state), .be_i(be_q), .deep_i(deep_q),
    .cs_no(ram_cs_no), .we_no(ram_we_no), .oe_no(ram_oe_no),
    .bsel_no(bsel_n), .mode_o(ram_mode_o), .dq_oe_o(ram_dq_oe_o)
  );

  assign ram_lb_no = bsel_n[0];
  assign ram_ub_no = bsel_n[1];

  psram_rdpath #(.BE_W(BE_W)) u_rd (
    .clk_i, .rst_ni, .capture_i(capture), .be_i(be_q), .dq_i(ram_dq_i),
    .rdata_o(rdata_o), .valid_o(rdata_valid_o)
  );
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
  parameter int ADDR_W  = 20,
  parameter int MAX_LOW = 1250,
  parameter int WP_MIN  = 4,
  parameter int GAP_MIN = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ram_cs_no,
  input logic              ram_we_no,
  input logic              ram_oe_no,
  input logic              ram_mode_o,
  input logic              ram_dq_oe_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ready_o,
  input logic              rdata_valid_o
);
  int lo_run, we_run, hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run <= 0;
      we_run <= 0;
      hi_run <= GAP_MIN;
    end else begin
      lo_run <= ram_cs_no ? 0 : lo_run + 1;
      we_run <= ram_we_no ? 0 : we_run + 1;
      hi_run <= ram_cs_no ? ((hi_run < GAP_MIN) ? hi_run + 1 : hi_run) : 0;
    end
  end

  assert_ready_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ram_cs_no);
  assert_cs_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ram_cs_no) |-> hi_run >= GAP_MIN);
  assert_addr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_cs_no && !ram_we_no) |-> $stable(ram_addr_o));
  assert_dq_we_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_dq_oe_o |-> !ram_we_no);
  assert_we_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_no) |-> we_run >= WP_MIN);
  assert_oe_we_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_oe_no |-> ram_we_no);
  assert_bus_turn_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_oe_no |-> !$past(ram_dq_oe_o));
  assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |=> !rdata_valid_o);
  assert_mode_cs_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_mode_o |-> ram_cs_no);
  assert_cs_max_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_run <= MAX_LOW);
endmodule

bind psram_ctrl psram_ctrl_chk #(
  .ADDR_W(ADDR_W), .MAX_LOW(MAX_CS_LOW_CYC), .WP_MIN(WE_PULSE_CYC), .GAP_MIN(CS_GAP_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ram_cs_no(ram_cs_no), .ram_we_no(ram_we_no),
  .ram_oe_no(ram_oe_no), .ram_mode_o(ram_mode_o), .ram_dq_oe_o(ram_dq_oe_o),
  .ram_addr_o(ram_addr_o), .ready_o(ready_o), .rdata_valid_o(rdata_valid_o)
);

// File: tb/sim_psram_ctrl.sv
`timescale 1ns/1ps
module sim_psram_ctrl;
  localparam int AW       = 20;
  localparam int INIT     = 200;
  localparam int CYC_MIN  = 10;
  localparam int GAP      = 2;
  localparam int WP       = 4;
  localparam int MAXLOW   = 1250;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, sleep_req = 1'b0, sleep_deep = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic ready_o, rdata_valid_o, cs_n, we_n, oe_n, lb_n, ub_n, mode, dq_oe;
  logic [15:0] rdata_o, dq_o, dq_i;
  logic [AW-1:0] ram_addr;

  always #4 clk = ~clk;

  psram_ctrl #(.ADDR_W(AW), .INIT_WAIT_CYC(INIT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .sleep_req_i(sleep_req), .sleep_deep_i(sleep_deep),
    .ready_o(ready_o), .rdata_valid_o(rdata_valid_o), .rdata_o(rdata_o),
    .ram_addr_o(ram_addr), .ram_cs_no(cs_n), .ram_we_no(we_n), .ram_oe_no(oe_n),
    .ram_lb_no(lb_n), .ram_ub_no(ub_n), .ram_mode_o(mode), .ram_dq_o(dq_o),
    .ram_dq_oe_o(dq_oe), .ram_dq_i(dq_i)
  );

  // memory model: drives the full word, masking is the controller's job
  logic [15:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  always @(posedge clk) if (!cs_n && !we_n && dq_oe) begin
    if (!lb_n) mem[ram_addr[7:0]][7:0]  <= dq_o[7:0];
    if (!ub_n) mem[ram_addr[7:0]][15:8] <= dq_o[15:8];
  end
  assign dq_i = (!cs_n && !oe_n) ? mem[ram_addr[7:0]] : 16'hA5A5;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pin monitor
  bit in_init = 1, seen_low = 0, prev_cs = 1, prev_we = 1, prev_dq_oe = 0, deep_flag = 0;
  logic [AW-1:0] prev_addr = '0;
  int lo_run = 0, hi_run = 0, we_run = 0;
  int min_lo = 1 << 30, max_lo = 0, min_hi = 1 << 30, min_we = 1 << 30;
  int dummies = 0, wait_cyc = 0, init_oe_bad = 0, cs_falls = 0;
  int v_addr = 0, v_dq = 0, v_oe = 0, v_mode = 0;

  always @(negedge clk) if (rst_n) begin
    if (in_init) begin
      if (ready_o) in_init = 0;
      else begin
        if (!cs_n && prev_cs) dummies++;
        if (dummies == 0 && cs_n && mode) wait_cyc++;
        if (!oe_n) init_oe_bad++;
      end
    end
    if (!cs_n && prev_cs) cs_falls++;
    if (!cs_n) begin
      lo_run++;
      if (prev_cs && seen_low && hi_run < min_hi) min_hi = hi_run;
      hi_run = 0;
    end else begin
      if (!prev_cs) begin
        if (lo_run < min_lo) min_lo = lo_run;
        if (lo_run > max_lo) max_lo = lo_run;
        seen_low = 1;
      end
      lo_run = 0;
      hi_run++;
    end
    if (!we_n) we_run++;
    else begin
      if (!prev_we && we_run < min_we) min_we = we_run;
      we_run = 0;
    end
    if (ram_addr != prev_addr && !cs_n && !we_n) v_addr++;
    if (dq_oe && we_n) v_dq++;
    if (!oe_n && (!we_n || prev_dq_oe)) v_oe++;
    if (!mode && (!deep_flag || !cs_n)) v_mode++;
    prev_cs = cs_n; prev_we = we_n; prev_dq_oe = dq_oe; prev_addr = ram_addr;
  end

  // {write, be[1:0], addr[7:0], wdata[15:0], expected[15:0]}
  localparam logic [42:0] VEC [10] = '{
    {1'b1, 2'b11, 8'h10, 16'h1234, 16'h0000},
    {1'b1, 2'b11, 8'h11, 16'hABCD, 16'h0000},
    {1'b0, 2'b11, 8'h10, 16'h0000, 16'h1234},
    {1'b0, 2'b01, 8'h11, 16'h0000, 16'h00CD},
    {1'b0, 2'b10, 8'h11, 16'h0000, 16'hAB00},
    {1'b1, 2'b01, 8'h10, 16'h00FF, 16'h0000},
    {1'b0, 2'b11, 8'h10, 16'h0000, 16'h12FF},
    {1'b1, 2'b10, 8'h11, 16'h5500, 16'h0000},
    {1'b0, 2'b11, 8'h11, 16'h0000, 16'h55CD},
    {1'b0, 2'b00, 8'h11, 16'h0000, 16'h0000}
  };

  task automatic wait_ready();
    do begin @(posedge clk); #2; end while (!ready_o);
  endtask

  task automatic access(input bit w, input logic [1:0] be, input logic [7:0] a,
                        input logic [15:0] wd, input logic [15:0] exp, input string req);
    wait_ready();
    req_valid = 1; req_write = w; req_be = be; req_addr = AW'(a); req_wdata = wd;
    @(posedge clk); #2;
    req_valid = 0;
    if (!w) begin
      int t = 0;
      do begin @(negedge clk); t++; end while (!rdata_valid_o && t < 100);
      chk(rdata_valid_o && rdata_o == exp, req, rdata_o, exp);
      @(negedge clk);
      chk(!rdata_valid_o, "R8 valid one cycle", rdata_valid_o, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!ready_o && cs_n && mode && !dq_oe && !rdata_valid_o, "R2 reset state",
        {ready_o, cs_n, mode, dq_oe}, 4'b0110);
    @(posedge clk); #2; rst_n = 1;
    wait_ready();
    #1;
    chk(wait_cyc >= INIT, "R1 start-up wait", wait_cyc, INIT);
    chk(dummies == 3, "R2 dummy read count", dummies, 3);
    chk(init_oe_bad == 0, "R2 oe high in dummies", init_oe_bad, 0);

    for (int i = 0; i < 10; i++) begin
      logic [42:0] v;
      v = VEC[i];
      access(v[42], v[41:40], v[39:32], v[31:16], v[15:0],
             v[42] ? "write" : "R8 R9 read data");
    end

    // R10: retaining standby
    wait_ready();
    begin
      int falls0;
      falls0 = cs_falls;
      sleep_deep = 0; sleep_req = 1;
      repeat (4) @(negedge clk);
      chk(!ready_o && cs_n && mode, "R10 standby pins", {ready_o, cs_n, mode}, 3'b011);
      @(posedge clk); #2; sleep_req = 0;
      wait_ready();
      chk(cs_falls == falls0, "R10 no re-init", cs_falls - falls0, 0);
    end
    access(0, 2'b11, 8'h10, 16'h0, 16'h12FF, "R10 data after standby");

    // R11: losing standby
    wait_ready();
    deep_flag = 1; sleep_deep = 1; sleep_req = 1;
    repeat (4) @(negedge clk);
    chk(!mode && cs_n && !ready_o, "R11 deep pins", {mode, cs_n, ready_o}, 3'b010);
    repeat (10) @(negedge clk);
    @(posedge clk); #2;
    sleep_req = 0; in_init = 1; dummies = 0; wait_cyc = 0; init_oe_bad = 0;
    @(posedge clk); #2; deep_flag = 0;
    wait_ready();
    #1;
    chk(wait_cyc >= INIT, "R11 re-init wait", wait_cyc, INIT);
    chk(dummies == 3, "R11 re-init dummies", dummies, 3);
    chk(init_oe_bad == 0, "R11 re-init oe high", init_oe_bad, 0);
    access(1, 2'b11, 8'h20, 16'hC3C3, 16'h0, "write");
    access(0, 2'b11, 8'h20, 16'h0, 16'hC3C3, "R8 read after wake");

    repeat (5) @(negedge clk);
    chk(min_lo >= CYC_MIN, "R3 min cs low", min_lo, CYC_MIN);
    chk(min_hi >= GAP, "R4 min cs high", min_hi, GAP);
    chk(v_addr == 0, "R5 addr change", v_addr, 0);
    chk(min_we >= WP, "R6 we pulse", min_we, WP);
    chk(v_dq == 0, "R6 bus drive", v_dq, 0);
    chk(v_oe == 0, "R7 oe turnaround", v_oe, 0);
    chk(v_mode == 0, "R12 mode high", v_mode, 0);
    chk(max_lo <= MAXLOW, "R13 max cs low", max_lo, MAXLOW);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule